// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache

This block is a read-only instruction cache that sits between a processor's fetch stage and the next memory level. Each fetch address selects exactly one line frame. That frame holds a tag, a valid flag and one whole line. When the frame is valid and its tag matches, the line goes back to the core as one 256-bit fetch packet. Otherwise the block asks the next level for the aligned line. It then writes the returned data into the frame, records the tag, marks the frame valid and passes the same data to the core. Because every address has a single home frame, no replacement state is kept.

A separate invalidate input lets coherence logic remove a line after a DMA engine has overwritten the backing memory. An invalidate that names the line currently being filled makes the fill land invalid.

Back-pressure rules:
- Fetch requests use a valid/ready handshake. Ready is high only while the cache is idle, so one fetch is in flight at a time.
- The packet output holds valid and data steady until the core raises ready.
- The fill request holds valid and address steady until the next level raises ready.
- The fill response has no ready. The cache accepts it whenever it is waiting for one.

Top module: `icache_dm`

## Requirements
- R1: After reset every frame is invalid. The idle outputs are fetch_ready=1, pkt_valid=0 and fill_req_valid=0. The first fetch to any address misses.
- R2: Address bits [13:5] pick the frame and bits [31:14] are the tag. Bits [4:0] do not affect the lookup. Instruction i of the packet occupies bits [32i+31:32i].
- R3: A fetch accepted at a clock edge that finds a valid frame with a matching tag raises pkt_valid after the second following edge, with the stored line and no fill request.
- R4: A missing fetch raises fill_req_valid after the second edge following acceptance. The fill address is the fetch address with bits [4:0] cleared.
- R5: When fill_rsp_valid arrives while waiting, the line, tag and valid flag are written, the returned data appears on pkt_data after the next edge, and a later fetch of that line hits.
- R6: Two lines with equal index bits and different tags evict each other.
- R7: fetch_ready is low from acceptance until the packet handshake. pkt_valid/pkt_data and fill_req_valid/fill_req_addr are held stable while the matching ready is low.
- R8: An invalidate whose address tag matches a valid frame at its index clears that frame. An invalidate with a different tag leaves the frame intact.
- R9: An invalidate naming the line whose miss is pending, at any point from the lookup cycle through the fill cycle, leaves that line invalid after the fill. The filled packet is still delivered. An invalidate of another line does not affect the fill.
- R10: An invalidate of the looked-up line in the lookup cycle itself turns that lookup into a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_valid | input | 1 | Fetch request valid |
| fetch_ready | output | 1 | Cache can accept a fetch |
| fetch_addr | input | 32 | Fetch byte address |
| pkt_valid | output | 1 | Fetch packet valid |
| pkt_ready | input | 1 | Core accepts the packet |
| pkt_data | output | 256 | Eight 32-bit instructions |
| fill_req_valid | output | 1 | Line request to next level |
| fill_req_ready | input | 1 | Next level accepts the request |
| fill_req_addr | output | 32 | Line-aligned request address |
| fill_rsp_valid | input | 1 | Line data from next level valid |
| fill_rsp_data | input | 256 | Returned line |
| inv_valid | input | 1 | Invalidate command strobe |
| inv_addr | input | 32 | Address of the line to invalidate |

## Verification
The bench builds the cache with its defaults: 512 frames of 32 bytes and 32-bit addresses. With these values the 9-bit index and 18-bit tag fields are the ones a real core would see. Aliasing addresses 16 KB apart therefore exercises conflict eviction on real field boundaries. The invalidate corner cases are reachable with exact timing: a strobe in the lookup cycle, a strobe while the fill request stalls, and a strobe aimed at a different tag in the same frame. A behavioural model compares every output on every clock.

// File: rtl/ic_pkg.sv
package ic_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_MREQ,
    ST_WAIT,
    ST_RESP
  } ic_state_e;
endpackage

// File: rtl/ic_tag_store.sv
module ic_tag_store #(
  parameter int NUM_LINES = 512,
  parameter int TAG_W     = 18,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_vld,
  input  logic             inv_en,
  input  logic [IDX_W-1:0] inv_idx,
  input  logic [TAG_W-1:0] inv_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_vld
);
  logic [NUM_LINES-1:0] vld_q;
  logic [TAG_W-1:0]     tag_q [NUM_LINES];
  logic                 inv_hit;

  assign inv_hit = inv_en && vld_q[inv_idx] && (tag_q[inv_idx] == inv_tag);
  assign rd_tag  = tag_q[rd_idx];
  assign rd_vld  = vld_q[rd_idx];

  // Fill write outranks invalidate on the same frame: the invalidate then
  // names the outgoing tag, or the fill already carries wr_vld=0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      for (int i = 0; i < NUM_LINES; i++) begin
        if (wr_en && wr_idx == IDX_W'(i)) begin
          vld_q[i] <= wr_vld;
        end else if (inv_hit && inv_idx == IDX_W'(i)) begin
          vld_q[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx] <= wr_tag;
  end

  a_r8_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_hit && !(wr_en && wr_idx == inv_idx)) |=> !vld_q[$past(inv_idx)]);

  a_r5_fill_writes: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (vld_q[$past(wr_idx)] == $past(wr_vld)) && (tag_q[$past(wr_idx)] == $past(wr_tag)));
endmodule

// File: rtl/ic_data_ram.sv
module ic_data_ram #(
  parameter int NUM_LINES = 512,
  parameter int LINE_W    = 256,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [LINE_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  raddr,
  output logic [LINE_W-1:0] rdata
);
  logic [LINE_W-1:0] mem [NUM_LINES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/icache_dm.sv
module icache_dm
  import ic_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int NUM_LINES  = 512
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fetch_valid,
  output logic                    fetch_ready,
  input  logic [ADDR_W-1:0]       fetch_addr,
  output logic                    pkt_valid,
  input  logic                    pkt_ready,
  output logic [LINE_BYTES*8-1:0] pkt_data,
  output logic                    fill_req_valid,
  input  logic                    fill_req_ready,
  output logic [ADDR_W-1:0]       fill_req_addr,
  input  logic                    fill_rsp_valid,
  input  logic [LINE_BYTES*8-1:0] fill_rsp_data,
  input  logic                    inv_valid,
  input  logic [ADDR_W-1:0]       inv_addr
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int LINE_W = LINE_BYTES * 8;

  ic_state_e         state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              kill_q;
  logic [LINE_W-1:0] pkt_q;

  logic              accept;
  logic [IDX_W-1:0]  idx_q;
  logic [TAG_W-1:0]  tag_cur;
  logic [TAG_W-1:0]  rd_tag;
  logic              rd_vld;
  logic              inv_same;
  logic              lookup_hit;
  logic              fill_done;
  logic [LINE_W-1:0] ram_rdata;
  logic              unused_bits;

  assign accept      = fetch_valid && fetch_ready;
  assign idx_q       = addr_q[OFF_W +: IDX_W];
  assign tag_cur     = addr_q[ADDR_W-1 -: TAG_W];
  assign inv_same    = inv_valid && (inv_addr[ADDR_W-1:OFF_W] == addr_q[ADDR_W-1:OFF_W]);
  assign lookup_hit  = rd_vld && (rd_tag == tag_cur) && !inv_same;
  assign fill_done   = (state_q == ST_WAIT) && fill_rsp_valid;
  assign unused_bits = ^{inv_addr[OFF_W-1:0], addr_q[OFF_W-1:0]};

  ic_tag_store #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) tags_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (idx_q),
    .rd_tag  (rd_tag),
    .rd_vld  (rd_vld),
    .inv_en  (inv_valid),
    .inv_idx (inv_addr[OFF_W +: IDX_W]),
    .inv_tag (inv_addr[ADDR_W-1 -: TAG_W]),
    .wr_en   (fill_done),
    .wr_idx  (idx_q),
    .wr_tag  (tag_cur),
    .wr_vld  (!(kill_q || inv_same))
  );

  ic_data_ram #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) data_i (
    .clk   (clk),
    .we    (fill_done),
    .waddr (idx_q),
    .wdata (fill_rsp_data),
    .re    (accept),
    .raddr (fetch_addr[OFF_W +: IDX_W]),
    .rdata (ram_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      kill_q  <= 1'b0;
      pkt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            addr_q  <= fetch_addr;
            kill_q  <= 1'b0;
            state_q <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (lookup_hit) begin
            pkt_q   <= ram_rdata;
            state_q <= ST_RESP;
          end else begin
            if (inv_same) kill_q <= 1'b1;
            state_q <= ST_MREQ;
          end
        end
        ST_MREQ: begin
          if (inv_same) kill_q <= 1'b1;
          if (fill_req_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (inv_same) kill_q <= 1'b1;
          if (fill_rsp_valid) begin
            pkt_q   <= fill_rsp_data;
            state_q <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (pkt_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign fetch_ready    = (state_q == ST_IDLE);
  assign pkt_valid      = (state_q == ST_RESP);
  assign pkt_data       = pkt_q;
  assign fill_req_valid = (state_q == ST_MREQ);
  assign fill_req_addr  = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  a_r7_busy_blocks_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req_valid || pkt_valid) |-> !fetch_ready);

  a_r7_fill_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req_valid && !fill_req_ready) |=> (fill_req_valid && $stable(fill_req_addr)));

  a_r7_pkt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_data)));

  a_r4_fill_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req_valid |-> (fill_req_addr[OFF_W-1:0] == '0));

  a_r5_fill_to_pkt: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> (pkt_valid && pkt_data == $past(fill_rsp_data)));
endmodule

// File: tb/icache_dm_tb_top.sv
module icache_dm_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         fetch_valid;
  logic         fetch_ready;
  logic [31:0]  fetch_addr;
  logic         pkt_valid;
  logic         pkt_ready;
  logic [255:0] pkt_data;
  logic         fill_req_valid;
  logic         fill_req_ready;
  logic [31:0]  fill_req_addr;
  logic         fill_rsp_valid;
  logic [255:0] fill_rsp_data;
  logic         inv_valid;
  logic [31:0]  inv_addr;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  icache_dm dut_i (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_addr(fetch_addr),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_data(pkt_data),
    .fill_req_valid(fill_req_valid), .fill_req_ready(fill_req_ready), .fill_req_addr(fill_req_addr),
    .fill_rsp_valid(fill_rsp_valid), .fill_rsp_data(fill_rsp_data),
    .inv_valid(inv_valid), .inv_addr(inv_addr)
  );

  task automatic chk(input bit ok, input string rq, input logic [255:0] act, input logic [255:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  // Line content per R2: word i = line address ^ i*0x01010101 ^ 0x5A000000
  function automatic logic [255:0] gold(input logic [31:0] a);
    logic [255:0] v;
    for (int i = 0; i < 8; i++)
      v[32*i +: 32] = {a[31:5], 5'b0} ^ (32'h01010101 * i) ^ 32'h5A000000;
    return v;
  endfunction

  // ---------------- behavioural reference model ----------------
  bit            vm [int];
  logic [17:0]   tm [int];
  logic [255:0]  dm [int];
  int            m_ph;
  logic [31:0]   m_addr;
  bit            m_kill;
  logic [255:0]  m_pkt;
  bit            m_inv_same;
  bit            m_fill_now;
  int            m_ix;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_addr = '0; m_kill = 0; m_pkt = '0;
      vm.delete(); tm.delete(); dm.delete();
    end else begin
      m_inv_same = inv_valid && (inv_addr[31:5] == m_addr[31:5]);
      m_fill_now = 0;
      m_ix = int'(m_addr[13:5]);
      case (m_ph)
        0: if (fetch_valid) begin m_addr = fetch_addr; m_kill = 0; m_ph = 1; end
        1: begin
          if (vm.exists(m_ix) && vm[m_ix] && tm[m_ix] == m_addr[31:14] && !m_inv_same) begin
            m_pkt = dm[m_ix]; m_ph = 4;
          end else begin
            if (m_inv_same) m_kill = 1;
            m_ph = 2;
          end
        end
        2: begin if (m_inv_same) m_kill = 1; if (fill_req_ready) m_ph = 3; end
        3: begin
          if (m_inv_same) m_kill = 1;
          if (fill_rsp_valid) begin m_fill_now = 1; m_pkt = fill_rsp_data; m_ph = 4; end
        end
        default: if (pkt_ready) m_ph = 0;
      endcase
      if (inv_valid) begin
        int iix;
        iix = int'(inv_addr[13:5]);
        if (vm.exists(iix) && vm[iix] && tm[iix] == inv_addr[31:14]) vm[iix] = 0;
      end
      if (m_fill_now) begin
        m_ix = int'(m_addr[13:5]);
        dm[m_ix] = fill_rsp_data; tm[m_ix] = m_addr[31:14]; vm[m_ix] = !m_kill;
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog act=%0d exp=<100000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
    if (rst_n) begin
      chk(fetch_ready == (m_ph == 0), "R7 fetch_ready", 256'(fetch_ready), 256'(m_ph == 0));
      chk(pkt_valid == (m_ph == 4), "R3 pkt_valid", 256'(pkt_valid), 256'(m_ph == 4));
      chk(fill_req_valid == (m_ph == 2), "R4 fill_req_valid", 256'(fill_req_valid), 256'(m_ph == 2));
      if (m_ph == 2)
        chk(fill_req_addr == {m_addr[31:5], 5'b0}, "R4 fill_req_addr", 256'(fill_req_addr), 256'({m_addr[31:5], 5'b0}));
      if (m_ph == 4)
        chk(pkt_data == m_pkt, "R5 pkt_data", pkt_data, m_pkt);
    end
  end

  // inv_mode: 0 none, 1 strobe on first cycle of the fill request, 2 strobe in the lookup cycle
  task automatic fetch(input logic [31:0] a, input int inv_mode, input logic [31:0] ia,
                       input bit exp_miss, input string rq);
    bit saw = 0; bit done = 0;
    int cyc = 1; int first_req = -1; int first_pkt = -1; int req_cnt = 0; int pkt_cnt = 0; int cd = 0;
    fetch_valid = 1; fetch_addr = a;
    @(negedge clk);
    fetch_valid = 0;
    if (inv_mode == 2) begin inv_valid = 1; inv_addr = ia; end
    while (!done && cyc < 60) begin
      @(negedge clk);
      cyc++;
      inv_valid = 0; fill_rsp_valid = 0;
      if (cd > 0) begin
        cd--;
        if (cd == 0) begin fill_rsp_valid = 1; fill_rsp_data = gold(a); end
      end
      if (fill_req_valid) begin
        if (!saw) begin
          saw = 1; first_req = cyc;
          if (inv_mode == 1) begin inv_valid = 1; inv_addr = ia; end
        end
        req_cnt++;
        fill_req_ready = (req_cnt >= 2);
        if (fill_req_ready) cd = 3;
      end else begin
        fill_req_ready = 0;
      end
      if (pkt_valid) begin
        pkt_cnt++;
        if (pkt_cnt == 1) first_pkt = cyc;
        if (pkt_cnt == 2) begin
          chk(pkt_data == gold(a), {rq, " packet"}, pkt_data, gold(a));
          pkt_ready = 1;
        end
      end else if (pkt_ready) begin
        pkt_ready = 0; done = 1;
      end
    end
    chk(done, {rq, " completed"}, 256'(done), 256'(1));
    chk(saw == exp_miss, {rq, " miss"}, 256'(saw), 256'(exp_miss));
    if (!exp_miss) chk(first_pkt == 2, {rq, " R3 hit latency"}, 256'(first_pkt), 256'(2));
    else           chk(first_req == 2, {rq, " R4 miss latency"}, 256'(first_req), 256'(2));
  endtask

  task automatic invalidate(input logic [31:0] ia);
    inv_valid = 1; inv_addr = ia;
    @(negedge clk);
    inv_valid = 0;
  endtask

  initial begin
    rst_n = 0; fetch_valid = 0; fetch_addr = '0; pkt_ready = 0; fill_req_ready = 0;
    fill_rsp_valid = 0; fill_rsp_data = '0; inv_valid = 0; inv_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(fetch_ready == 1, "R1 fetch_ready", 256'(fetch_ready), 256'(1));
    chk(pkt_valid == 0, "R1 pkt_valid", 256'(pkt_valid), 256'(0));
    chk(fill_req_valid == 0, "R1 fill_req_valid", 256'(fill_req_valid), 256'(0));

    fetch(32'h0000_1040, 0, '0, 1, "R1 cold");
    fetch(32'h0000_1040, 0, '0, 0, "R3 warm");
    fetch(32'h0000_1054, 0, '0, 0, "R2 offset");
    fetch(32'h0000_5040, 0, '0, 1, "R6 alias in");
    fetch(32'h0000_1040, 0, '0, 1, "R6 evicted");
    fetch(32'h0000_1040, 0, '0, 0, "R6 back");

    fetch(32'h0123_4560, 0, '0, 1, "R4 fill");
    invalidate(32'h0123_0560);
    fetch(32'h0123_4560, 0, '0, 0, "R8 tag differs");
    invalidate(32'h0123_457C);
    fetch(32'h0123_4560, 0, '0, 1, "R8 cleared");

    fetch(32'h0000_2000, 1, 32'h0000_2008, 1, "R9 strobe in fill");
    fetch(32'h0000_2000, 0, '0, 1, "R9 left invalid");
    fetch(32'h0000_2000, 0, '0, 0, "R9 refilled");
    fetch(32'h0000_2000, 2, 32'h0000_2000, 1, "R10 strobe at lookup");
    fetch(32'h0000_2000, 0, '0, 1, "R10 then invalid");

    fetch(32'h0000_3020, 1, 32'h0000_7020, 1, "R9 other line");
    fetch(32'h0000_3020, 0, '0, 0, "R9 other line kept");

    for (int i = 0; i < 8; i++) fetch(32'h8000_0000 + 32'(i * 32), 0, '0, 1, "R5 sweep miss");
    for (int i = 0; i < 8; i++) fetch(32'h8000_0004 + 32'(i * 32), 0, '0, 0, "R5 sweep hit");

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule